// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, given only the address it is fetched from. It runs two predictors side by side and a chooser that decides which one to trust for each branch. The first predictor is two-level and local: a per-branch shift register of recent outcomes selects a 2-bit saturating counter. The second is global: a shared shift register of the most recent outcomes of all branches selects its own 2-bit counter. The chooser is a table of 2-bit counters selected by branch address. It learns which of the two predictors does better on each branch.

Lookup is purely combinational from `lookup_pc` and the current table state, so the prediction is ready in the same cycle as the fetch. When a branch resolves, the fetch stage or back end presents its address and real direction with `upd_valid`. All tables and both history registers are then trained at the next rising clock edge. All state is held in flip-flops and returns to a known value on a synchronous active-high reset.

Top module: `tourney_bp`

## Requirements
- R1: After reset every 2-bit counter holds 01 and every history register holds 000. Every lookup address therefore yields pred_taken, pred_local, pred_global and pred_use_global all 0.
- R2: The per-branch tables (local history and chooser) are indexed by address bits [4:2] only. Addresses that differ only in other bits share the same entries.
- R3: On a valid resolve, the branch's 3-bit local history shifts left and the outcome enters at bit 0 (1 = taken).
- R4: pred_local is bit 1 of the local counter selected by the branch's 3-bit local history. On resolve, that counter counts up for taken and down for not-taken, saturating at 11 and at 00.
- R5: pred_global is bit 1 of the global counter selected by the 3-bit global history. On resolve, that counter is trained in the same saturating way.
- R6: On a valid resolve, the global history shifts left and the outcome enters at bit 0.
- R7: The chooser counter of the resolving branch changes only when its local and global predictions differ. It steps toward 11 when the global prediction matched the outcome and toward 00 when the local prediction matched. pred_use_global is bit 1 of the chooser counter.
- R8: pred_taken equals pred_global when pred_use_global is 1, and pred_local otherwise.
- R9: Training uses the histories and counters as they stand before the resolve edge. A lookup in the same cycle as a resolve sees only the state before that update.
- R10: While upd_valid is 0, no table or history changes, whatever the values on upd_pc and upd_taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lookup_pc | input | ADDR_W | Fetch address to predict |
| upd_valid | input | 1 | A branch has resolved this cycle |
| upd_pc | input | ADDR_W | Address of the resolving branch |
| upd_taken | input | 1 | Real direction of the resolving branch (1 = taken) |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Prediction of the local two-level predictor |
| pred_global | output | 1 | Prediction of the global-history predictor |
| pred_use_global | output | 1 | Chooser picks the global predictor |

## Verification
A corrupted history register or counter does not show up at once. It sends a later lookup to the wrong second-level counter, so the error appears at pred_local or pred_global only when that entry holds a different top bit. This can be one or several resolves after the fault. A chooser that trains on agreement, or steps the wrong way, shows at pred_use_global and pred_taken only after enough disagreements have moved it across the midpoint. For this reason the outputs are compared against an arithmetic model for every lookup address over thousands of resolves with mixed outcomes. The idle cycles and the cycles with a lookup and a resolve together are where a missing valid gate or a wrong-cycle update shows up first.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int CTR_W = 2;

    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MIN   = '0;
    localparam ctr_t CTR_MAX   = '1;
    localparam ctr_t CTR_RESET = ctr_t'(1);

    // Component predictions and chooser decision for one address
    typedef struct packed {
        logic loc_tkn;
        logic glb_tkn;
        logic sel_glb;
    } comp_pred_t;

    function automatic ctr_t sat_step(input ctr_t c, input logic up);
        if (up) begin
            return (c == CTR_MAX) ? c : ctr_t'(c + 1'b1);
        end
        return (c == CTR_MIN) ? c : ctr_t'(c - 1'b1);
    endfunction

    function automatic logic ctr_dir(input ctr_t c);
        return c[CTR_W-1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output bp_pkg::ctr_t     rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output bp_pkg::ctr_t     rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    import bp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= sat_step(mem[wr_idx], wr_up);
        end
    end

endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
    parameter int IDX_W  = 3,
    parameter int HIST_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [HIST_W-1:0] rd_a,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [HIST_W-1:0] rd_b,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= {mem[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 3,
    parameter int IDX_LSB = 2,
    parameter int HIST_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lookup_pc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    output logic              pred_taken,
    output logic              pred_local,
    output logic              pred_global,
    output logic              pred_use_global
);
    import bp_pkg::*;

    // Per-branch table index from the address
    logic [IDX_W-1:0]  lk_idx, up_idx;
    // Local histories read for lookup and for training
    logic [HIST_W-1:0] lk_lhist, up_lhist;
    // Global history register
    logic [HIST_W-1:0] ghr_q;

    ctr_t lk_pht, up_pht, lk_ght, ght_rd_b_unused, lk_ch, up_ch;
    comp_pred_t lk, up;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{lookup_pc, upd_pc, ght_rd_b_unused};

    assign lk_idx = lookup_pc[IDX_LSB +: IDX_W];
    assign up_idx = upd_pc[IDX_LSB +: IDX_W];

    bp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lhist (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_idx),
        .rd_a     (lk_lhist),
        .rd_b_idx (up_idx),
        .rd_b     (up_lhist),
        .wr_en    (upd_valid),
        .wr_idx   (up_idx),
        .wr_bit   (upd_taken)
    );

    bp_ctr_table #(.IDX_W(HIST_W)) u_pht (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_lhist),
        .rd_a     (lk_pht),
        .rd_b_idx (up_lhist),
        .rd_b     (up_pht),
        .wr_en    (upd_valid),
        .wr_idx   (up_lhist),
        .wr_up    (upd_taken)
    );

    bp_ctr_table #(.IDX_W(HIST_W)) u_ght (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ghr_q),
        .rd_a     (lk_ght),
        .rd_b_idx (ghr_q),
        .rd_b     (ght_rd_b_unused),
        .wr_en    (upd_valid),
        .wr_idx   (ghr_q),
        .wr_up    (upd_taken)
    );

    always_comb begin
        up.loc_tkn = ctr_dir(up_pht);
        up.glb_tkn = ctr_dir(lk_ght);
        up.sel_glb = ctr_dir(up_ch);
    end

    bp_ctr_table #(.IDX_W(IDX_W)) u_chooser (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (lk_idx),
        .rd_a     (lk_ch),
        .rd_b_idx (up_idx),
        .rd_b     (up_ch),
        .wr_en    (upd_valid && (up.loc_tkn != up.glb_tkn)),
        .wr_idx   (up_idx),
        .wr_up    (up.glb_tkn == upd_taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ghr_q <= '0;
        end else if (upd_valid) begin
            ghr_q <= {ghr_q[HIST_W-2:0], upd_taken};
        end
    end

    always_comb begin
        lk.loc_tkn = ctr_dir(lk_pht);
        lk.glb_tkn = ctr_dir(lk_ght);
        lk.sel_glb = ctr_dir(lk_ch);
    end

    assign pred_local      = lk.loc_tkn;
    assign pred_global     = lk.glb_tkn;
    assign pred_use_global = lk.sel_glb;
    assign pred_taken      = lk.sel_glb ? lk.glb_tkn : lk.loc_tkn;

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lookup_pc,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] ghr,
    input logic              pred_taken,
    input logic              pred_local,
    input logic              pred_global,
    input logic              pred_use_global
);

    // Reset leaves all counters weakly not-taken and the chooser on local
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> !pred_taken && !pred_local && !pred_global && !pred_use_global);

    // Global history takes the outcome at bit 0 and shifts the rest left
    p_ghr_shift_r6: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (ghr[0] == $past(upd_taken)) &&
                      (ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0])));

    // When both components agree the final prediction cannot differ
    p_agree_pick_r8: assert property (@(posedge clk) disable iff (rst)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // Idle resolve port leaves global history alone
    p_ghr_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghr));

    // Idle resolve port and an unchanged lookup keep every output steady
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid) && $stable(lookup_pc)) |->
            $stable({pred_taken, pred_local, pred_global, pred_use_global}));

endmodule

bind tourney_bp bp_checker #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .lookup_pc       (lookup_pc),
    .upd_valid       (upd_valid),
    .upd_taken       (upd_taken),
    .ghr             (ghr_q),
    .pred_taken      (pred_taken),
    .pred_local      (pred_local),
    .pred_global     (pred_global),
    .pred_use_global (pred_use_global)
);

// File: tb/tourney_bp_tb.sv
module tourney_bp_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lookup_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pred_taken, pred_local, pred_global, pred_use_global;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state
    logic [2:0] lh_m  [8];
    logic [1:0] pht_m [8];
    logic [1:0] ght_m [8];
    logic [1:0] ch_m  [8];
    logic [2:0] ghr_m;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    tourney_bp u_dut (
        .clk             (clk),
        .rst             (rst),
        .lookup_pc       (lookup_pc),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .pred_taken      (pred_taken),
        .pred_local      (pred_local),
        .pred_global     (pred_global),
        .pred_use_global (pred_use_global)
    );

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? c : c + 2'b01;
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            lh_m[i] = 3'b000; pht_m[i] = 2'b01; ght_m[i] = 2'b01; ch_m[i] = 2'b01;
        end
        ghr_m = 3'b000;
    endtask

    // One cycle: drive, check lookup against pre-update model, then train model
    task automatic step(input logic [31:0] lpc, input logic uv,
                        input logic [31:0] upc, input logic ut, input string tag);
        logic [2:0] li, ui, uh;
        logic el, eg, ec, ul, ug;
        @(negedge clk);
        lookup_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        li = lpc[4:2];
        el = pht_m[lh_m[li]][1];
        eg = ght_m[ghr_m][1];
        ec = ch_m[li][1];
        check(pred_local,      el,            $sformatf("%s/R4 pred_local pc=%h", tag, lpc));
        check(pred_global,     eg,            $sformatf("%s/R5 pred_global pc=%h", tag, lpc));
        check(pred_use_global, ec,            $sformatf("%s/R7 pred_use_global pc=%h", tag, lpc));
        check(pred_taken,      ec ? eg : el,  $sformatf("%s/R8 pred_taken pc=%h", tag, lpc));
        @(posedge clk);
        if (uv) begin
            ui = upc[4:2];
            uh = lh_m[ui];
            ul = pht_m[uh][1];
            ug = ght_m[ghr_m][1];
            pht_m[uh] = sat(pht_m[uh], ut);
            ght_m[ghr_m] = sat(ght_m[ghr_m], ut);
            if (ul != ug) ch_m[ui] = sat(ch_m[ui], ug == ut);
            lh_m[ui] = {uh[1:0], ut};
            ghr_m = {ghr_m[1:0], ut};
        end
    endtask

    task automatic sweep_lookups(input string tag);
        for (int a = 0; a < 8; a++) begin
            step(32'h0000_4000 | (a << 2), 1'b0, 32'h0, 1'b0, tag);
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every address predicts 0 out of reset
        sweep_lookups("R1");

        // R3 R6: repeated taken at one branch builds local and global history
        for (int k = 0; k < 5; k++) step(32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R3_R6");
        sweep_lookups("R3_R6");
        for (int k = 0; k < 3; k++) step(32'h0000_0100, 1'b1, 32'h0000_0100, k[0], "R3_R6");
        sweep_lookups("R3_R6");

        // R4 R5 saturation: long runs of one direction
        for (int k = 0; k < 10; k++) step(32'h0000_0108, 1'b1, 32'h0000_0108, 1'b0, "R4_R5sat");
        sweep_lookups("R4_R5sat");
        for (int k = 0; k < 10; k++) step(32'h0000_0108, 1'b1, 32'h0000_0108, 1'b1, "R4_R5sat");
        sweep_lookups("R4_R5sat");

        // R2: aliasing addresses share entries
        for (int k = 0; k < 12; k++) begin
            step(32'h0000_000C, 1'b1, 32'hFFFF_FF0F ^ (k << 8), (k % 3) != 0, "R2");
        end
        step(32'h1234_568F, 1'b0, 32'h0, 1'b0, "R2");
        step(32'h8000_002C, 1'b0, 32'h0, 1'b0, "R2");

        // R9: lookup of the very branch resolving in the same cycle
        for (int k = 0; k < 16; k++) begin
            step(32'h0000_0010 + (k[2:0] << 2), 1'b1, 32'h0000_0010 + (k[2:0] << 2),
                 k[1] ^ k[0], "R9");
        end

        // R10: idle resolve port with busy data lines
        for (int k = 0; k < 16; k++) begin
            lfsr = nxt(lfsr);
            step(32'h0000_0000 | (k[2:0] << 2), 1'b0, lfsr, lfsr[3], "R10");
        end
        sweep_lookups("R10");

        // Broad sweep: mixed patterns per index, idle gaps, random lookups (R5 R7)
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] upc;
            logic t;
            lfsr = nxt(lfsr);
            upc = {lfsr[31:5], lfsr[4:2], 2'b00};
            case (lfsr[4:3])
                2'b00: t = 1'b1;
                2'b01: t = k[0];
                2'b10: t = lfsr[11];
                default: t = (k % 3) == 0;
            endcase
            step({lfsr[15:8], lfsr[23:16], lfsr[7:0], lfsr[31:24]}, lfsr[9] | lfsr[13],
                 upc, t, "R5_R7sweep");
        end
        sweep_lookups("R5_R7sweep");

        // R1 again: reset in the middle of trained state
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b1;
        @(negedge clk);
        upd_valid = 1'b0;
        rst = 1'b0;
        model_reset();
        sweep_lookups("R1_rereset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule